// File: doc/BRIEF.md
# Packed Nibble Index Vector Lookup Unit

This block fills a destination vector by table lookup. A packed index vector supplies 4-bit indices, and the block picks a contiguous run of them (a segment). Each index selects an 8-bit or 16-bit entry from a small table held in the low bits of one or two table vectors. There are three operating modes. In the byte mode the table is sixteen 8-bit entries. In the paired halfword mode the table is split across two vectors, with eight 16-bit entries in each. In the wide halfword mode the table is sixteen 16-bit entries from one vector, and this mode needs a vector length of at least 256 bits.

The vector length is a compile-time parameter. It is a power of two from 128 to 2048 bits. A single valid strobe starts an operation. One cycle later the registered result appears together with a result-valid strobe and an undefined-operation flag. The cycle count never depends on the index or table data. Every destination element is written on every operation.

Top module: `nib_lut_unit`

## Requirements
- R1: With mode_i = 0 (byte), result element e (bits [8e+7:8e]) equals byte x of tab_a_i, held in bits [8x+7:8x], where x is nibble k = (VLEN/8)·seg_i + e of idx_vec_i and nibble k occupies bits [4k+3:4k].
- R2: In byte mode, seg_i values 0 and 1 are legal. The values 2 and 3 raise undef_o.
- R3: With mode_i = 1 (paired halfword), result element e (bits [16e+15:16e]) uses nibble k = (VLEN/16)·seg_i + e. An index x below 8 selects bits [16x+15:16x] of tab_a_i. An index x of 8 or more selects entry x−8 of tab_b_i. Every seg_i value from 0 to 3 is legal.
- R4: With mode_i = 2 (wide halfword) and VLEN ≥ 256, result element e equals bits [16x+15:16x] of tab_a_i, where x is found by the same nibble rule as in R3. Every seg_i value from 0 to 3 is legal.
- R5: With mode_i = 2 and VLEN < 256, the operation raises undef_o.
- R6: mode_i = 3 is reserved and always raises undef_o.
- R7: When undef_o is raised for an operation, res_o is all zeros.
- R8: valid_o is high in exactly the cycle after a cycle in which valid_i is sampled high, whatever the mode or data. It is low otherwise.
- R9: While valid_i is low, res_o and undef_o keep their values, even when the other inputs change.
- R10: An active rst_ni clears res_o, valid_o and undef_o at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Start an operation this cycle |
| mode_i | input | 2 | 0 byte, 1 paired halfword, 2 wide halfword, 3 reserved |
| seg_i | input | 2 | Segment number |
| idx_vec_i | input | VLEN | Packed 4-bit indices |
| tab_a_i | input | VLEN | First table vector |
| tab_b_i | input | VLEN | Second table vector (paired mode only) |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| undef_o | output | 1 | Operation was undefined |
| res_o | output | VLEN | Registered result vector |

## Verification
The hardest case to reach is the wide halfword mode on a short vector. A single instance with the default length never produces it. The bench therefore runs a second instance built with a 128-bit vector next to the 256-bit one. It sweeps every mode and every segment number on both instances. The index patterns are chosen so that the upper segments, and the tab_b_i half of the paired table, are both reached.

// File: rtl/nib_lut_pkg.sv
package nib_lut_pkg;
  typedef enum logic [1:0] {
    LUT_B8       = 2'd0,
    LUT_H16_PAIR = 2'd1,
    LUT_H16_WIDE = 2'd2,
    LUT_RSVD     = 2'd3
  } lut_mode_e;

  localparam int unsigned NIB_W   = 4;
  localparam int unsigned TBL_ENT = 16;
endpackage

// File: rtl/nib_lut_gate.sv
module nib_lut_gate
  import nib_lut_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  lut_mode_e  mode_i,
  input  logic [1:0] seg_i,
  output logic       undef_o
);
  localparam bit WIDE_OK = (VLEN >= 256);

  always_comb begin
    unique case (mode_i)
      LUT_B8:       undef_o = seg_i[1];
      LUT_H16_PAIR: undef_o = 1'b0;
      LUT_H16_WIDE: undef_o = !WIDE_OK;
      default:      undef_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/nib_lut_lane.sv
module nib_lut_lane
  import nib_lut_pkg::*;
#(
  parameter int unsigned ESIZE = 8
) (
  input  logic [NIB_W-1:0]         idx_i,
  input  logic [TBL_ENT*ESIZE-1:0] tbl_i,
  output logic [ESIZE-1:0]         elem_o
);
  logic [ESIZE-1:0] ent [TBL_ENT];

  for (genvar j = 0; j < TBL_ENT; j++) begin : g_ent
    assign ent[j] = tbl_i[j*ESIZE +: ESIZE];
  end

  assign elem_o = ent[idx_i];
endmodule

// File: rtl/nib_lut_unit.sv
module nib_lut_unit
  import nib_lut_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      mode_i,
  input  logic [1:0]      seg_i,
  input  logic [VLEN-1:0] idx_vec_i,
  input  logic [VLEN-1:0] tab_a_i,
  input  logic [VLEN-1:0] tab_b_i,
  output logic            valid_o,
  output logic            undef_o,
  output logic [VLEN-1:0] res_o
);
  localparam int unsigned NB = VLEN / 8;
  localparam int unsigned NH = VLEN / 16;
  localparam int unsigned SW = $clog2(VLEN) + 2;

  lut_mode_e mode;
  assign mode = lut_mode_e'(mode_i);

  logic undef;
  nib_lut_gate #(.VLEN(VLEN)) u_gate (
    .mode_i (mode),
    .seg_i  (seg_i),
    .undef_o(undef)
  );

  // segment start in bits: byte mode NB nibbles per segment, halfword NH
  logic [SW-1:0]   shamt;
  logic [VLEN-1:0] seg_nib;
  assign shamt   = (mode == LUT_B8) ? SW'(seg_i) * SW'(NB * NIB_W)
                                    : SW'(seg_i) * SW'(NH * NIB_W);
  assign seg_nib = idx_vec_i >> shamt;

  logic [127:0] tbl_b8;
  logic [255:0] tbl_h16;
  assign tbl_b8 = tab_a_i[127:0];

  if (VLEN >= 256) begin : g_wide
    assign tbl_h16 = (mode == LUT_H16_WIDE) ? tab_a_i[255:0]
                                            : {tab_b_i[127:0], tab_a_i[127:0]};
  end else begin : g_narrow
    assign tbl_h16 = {tab_b_i[127:0], tab_a_i[127:0]};
  end

  logic [VLEN-1:0] res_b8, res_h16;

  for (genvar e = 0; e < NB; e++) begin : g_b8
    nib_lut_lane #(.ESIZE(8)) u_lane (
      .idx_i (seg_nib[e*NIB_W +: NIB_W]),
      .tbl_i (tbl_b8),
      .elem_o(res_b8[e*8 +: 8])
    );
  end

  for (genvar e = 0; e < NH; e++) begin : g_h16
    nib_lut_lane #(.ESIZE(16)) u_lane (
      .idx_i (seg_nib[e*NIB_W +: NIB_W]),
      .tbl_i (tbl_h16),
      .elem_o(res_h16[e*16 +: 16])
    );
  end

  logic [VLEN-1:0] res_d;
  always_comb begin
    if (undef)              res_d = '0;
    else if (mode == LUT_B8) res_d = res_b8;
    else                    res_d = res_h16;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      undef_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        undef_o <= undef;
        res_o   <= res_d;
      end
    end
  end

  assert_vld_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_vld_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_undef_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && undef_o) |-> (res_o == '0));
  assert_byte_seg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd0 && seg_i[1]) |=> undef_o);
  assert_rsvd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd3) |=> undef_o);
  assert_pair_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd1) |=> !undef_o);
  assert_wide_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd2) |=> (undef_o == (VLEN < 256)));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(undef_o)));
endmodule

// File: tb/nib_lut_unit_tb.sv
module nib_lut_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [1:0] md = '0, sg = '0;
  logic [255:0] iv = '0, ta = '0, tb = '0;

  logic v_big, u_big, v_sml, u_sml;
  logic [255:0] r_big;
  logic [127:0] r_sml;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nib_lut_unit #(.VLEN(256)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .mode_i(md), .seg_i(sg),
    .idx_vec_i(iv), .tab_a_i(ta), .tab_b_i(tb),
    .valid_o(v_big), .undef_o(u_big), .res_o(r_big));

  nib_lut_unit #(.VLEN(128)) dut_small_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .mode_i(md), .seg_i(sg),
    .idx_vec_i(iv[127:0]), .tab_a_i(ta[127:0]), .tab_b_i(tb[127:0]),
    .valid_o(v_sml), .undef_o(u_sml), .res_o(r_sml));

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void model(input int vl, input logic [1:0] m, input logic [1:0] s,
                                input logic [255:0] i, input logic [255:0] a,
                                input logic [255:0] b, output logic [255:0] r,
                                output logic u);
    int n, k, x;
    u = (m == 2'd3) || (m == 2'd0 && s > 1) || (m == 2'd2 && vl < 256);
    r = '0;
    if (!u) begin
      n = (m == 2'd0) ? vl / 8 : vl / 16;
      for (int e = 0; e < n; e++) begin
        k = n * int'(s) + e;
        x = int'(i[4*k +: 4]);
        if (m == 2'd0)      r[8*e +: 8]   = a[8*x +: 8];
        else if (x < 8 || m == 2'd2) r[16*e +: 16] = a[16*x +: 16];
        else                r[16*e +: 16] = b[16*(x-8) +: 16];
      end
    end
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int j = 0; j < 8; j++) v[32*j +: 32] = $urandom;
    return v;
  endfunction

  function automatic string mreq(input logic [1:0] m, input logic [1:0] s);
    if (m == 2'd3) return "R6";
    if (m == 2'd0) return s > 1 ? "R2" : "R1";
    if (m == 2'd1) return "R3";
    return "R4";
  endfunction

  task automatic run_op();
    logic [255:0] eb, es;
    logic ub, us;
    model(256, md, sg, iv, ta, tb, eb, ub);
    model(128, md, sg, iv, ta, tb, es, us);
    vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0;
    chk("R8 valid big", {255'd0, v_big}, 256'd1);
    chk("R8 valid small", {255'd0, v_sml}, 256'd1);
    chk({mreq(md, sg), " big res"}, r_big, eb);
    chk({mreq(md, sg), " big undef"}, {255'd0, u_big}, {255'd0, ub});
    chk(md == 2'd2 ? "R5 small undef" : {mreq(md, sg), " small undef"},
        {255'd0, u_sml}, {255'd0, us});
    chk(us ? "R7 small res" : {mreq(md, sg), " small res"}, {128'd0, r_sml}, {128'd0, es[127:0]});
    if (ub) chk("R7 big zero", r_big, '0);
  endtask

  initial begin
    logic [255:0] keep_b;
    logic keep_u;
    #(CLK_PERIOD * 2000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [255:0] keep_r;
    logic keep_u;
    repeat (2) @(negedge clk);
    chk("R10 reset res", r_big, '0);
    chk("R10 reset valid/undef", {254'd0, v_big, u_big}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 6; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int s = 0; s < 4; s++) begin
          ta = rnd256();
          tb = rnd256();
          if (p == 0) for (int k = 0; k < 64; k++) iv[4*k +: 4] = 4'(k);
          else if (p == 1) iv = {64{4'hf}};
          else if (p == 2) for (int k = 0; k < 64; k++) iv[4*k +: 4] = 4'(15 - (k % 16));
          else iv = rnd256();
          md = 2'(m);
          sg = 2'(s);
          run_op();
        end
      end
    end
    // back-to-back then idle: latency and hold
    md = 2'd1; sg = 2'd2; iv = rnd256(); ta = rnd256(); tb = rnd256();
    run_op();
    keep_r = r_big; keep_u = u_big;
    md = 2'd3; iv = rnd256(); ta = rnd256();
    @(negedge clk);
    chk("R8 idle valid", {255'd0, v_big}, '0);
    chk("R9 hold res", r_big, keep_r);
    chk("R9 hold undef", {255'd0, u_big}, {255'd0, keep_u});
    // mid-run async reset
    md = 2'd0; sg = 2'd0; iv = rnd256(); ta = rnd256();
    run_op();
    #1 rst_n = 1'b0;
    #1;
    chk("R10 async res", r_big, '0);
    chk("R10 async valid/undef", {252'd0, v_big, u_big, v_sml, u_sml}, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule